// File: doc/BRIEF.md
# DMA Window Address Translator

This block sits on the inbound side of a PCI host bridge and decides, for every DMA address a device presents, whether it falls inside one of a small set of programmable windows into main memory. Each window is described by a base register, a size mask and a translated-base register, and can be enabled and switched between two modes from the upper bits of its base register.

A window in direct mode translates the address at once: the bits covered by the mask pass through and the bits above the mask come from the translated base. A window in scatter-gather mode does not translate. Instead it hands the page-table path a page index together with the table's physical address, which is held in the translated-base register. An address that matches no enabled window is reported as a miss. The block also holds a translation-buffer enable flag and emits a one-cycle invalidate-all strobe; the buffer itself lives elsewhere.

Software programs the windows through a simple write port (window index, register select, data). Lookups are presented with a valid qualifier and answered exactly one clock later.

Top module: `dma_win_xlate`

## Requirements
- R1: After reset every window is disabled, every lookup reports a miss, and the translation-buffer enable output is 0.
- R2: Register select codes are 0 base, 1 mask, 2 translated base, 3 buffer control, 4 invalidate-all. In write data for a base register, bit ADDR_W+1 (33 by default) enables the window and bit ADDR_W (32) selects scatter-gather mode; a window whose enable bit is 0 never hits.
- R3: A mask write stores data bits ADDR_W-1:0 with the low GRAN_BITS (20) bits forced to 0, so window sizes and base alignment are in 1 MB steps; the low GRAN_BITS bits of the base are ignored.
- R4: A window hits when (addr & ~M) equals (base & ~M), where M is the stored mask with its low GRAN_BITS bits set.
- R5: A direct-mode hit returns rsp_sg = 0 and rsp_addr = (addr & M) | (translated base & ~M).
- R6: A scatter-gather hit returns rsp_sg = 1, rsp_addr = (addr & M) >> PAGE_BITS (13), and rsp_ptbase = that window's translated base.
- R7: When several windows hit, the lowest-numbered window is reported.
- R8: A miss returns rsp_hit = 0, rsp_sg = 0, rsp_win = 0, rsp_addr = 0 and rsp_ptbase = 0.
- R9: The response to a lookup presented at clock edge N is visible after edge N; rsp_valid is 0 in any cycle that follows an edge without a request.
- R10: A control write sets tb_enable to data bit 7 and leaves it unchanged otherwise; an invalidate-all write raises tb_inval for exactly the one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | WIN_W (1) | Window index for the write |
| cfg_sel | input | 3 | Register select (see R2) |
| cfg_wdata | input | ADDR_W+2 (34) | Write data |
| req_valid | input | 1 | Lookup request qualifier |
| req_addr | input | ADDR_W (32) | Incoming DMA address |
| rsp_valid | output | 1 | Response qualifier |
| rsp_hit | output | 1 | Address hit an enabled window |
| rsp_win | output | WIN_W (1) | Index of the reporting window |
| rsp_sg | output | 1 | Hit was in scatter-gather mode |
| rsp_addr | output | ADDR_W (32) | Translated address or page index |
| rsp_ptbase | output | ADDR_W (32) | Page-table base for scatter-gather hits |
| tb_enable | output | 1 | Translation-buffer enable flag |
| tb_inval | output | 1 | Invalidate-all strobe |

## Verification
The assertions watch on every cycle that a response follows each request by one edge, that the lowest hitting window wins, that a miss leaves every response field clean, that a disabled window never raises a match, and that the enable flag and invalidate strobe change only on their own writes. The arithmetic of translation, the 1 MB rounding of masks and bases, the exact window edges and the scatter-gather page index and table base can only be shown by the bench's directed scenarios, which compare against values worked out from the register contents.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

   typedef enum logic [2:0] {
      SEL_BASE  = 3'd0,
      SEL_MASK  = 3'd1,
      SEL_XLAT  = 3'd2,
      SEL_CTRL  = 3'd3,
      SEL_INVAL = 3'd4
   } cfg_sel_e;

endpackage

// File: rtl/dwt_win_regs.sv
module dwt_win_regs #(
   parameter int ADDR_W    = 32,
   parameter int GRAN_BITS = 20,
   localparam int BASE_W   = ADDR_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_base,
   input  logic              wr_mask,
   input  logic              wr_xlat,
   input  logic [BASE_W-1:0] wdata,
   output logic              win_en,
   output logic              win_sg,
   output logic [ADDR_W-1:0] win_base,
   output logic [ADDR_W-1:0] win_emask,
   output logic [ADDR_W-1:0] win_xlat
);

   localparam int EN_BIT = ADDR_W + 1;
   localparam int SG_BIT = ADDR_W;
   localparam logic [ADDR_W-1:0] GRAN_ONES = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);

   logic [ADDR_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_en   <= 1'b0;
         win_sg   <= 1'b0;
         win_base <= '0;
         mask_q   <= '0;
         win_xlat <= '0;
      end else begin
         if (wr_base) begin
            win_en   <= wdata[EN_BIT];
            win_sg   <= wdata[SG_BIT];
            win_base <= wdata[ADDR_W-1:0];
         end
         if (wr_mask) mask_q   <= wdata[ADDR_W-1:0] & ~GRAN_ONES;
         if (wr_xlat) win_xlat <= wdata[ADDR_W-1:0];
      end
   end

   assign win_emask = mask_q | GRAN_ONES;

endmodule

// File: rtl/dwt_win_match.sv
module dwt_win_match #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              win_en,
   input  logic              win_sg,
   input  logic [ADDR_W-1:0] win_base,
   input  logic [ADDR_W-1:0] win_emask,
   input  logic [ADDR_W-1:0] win_xlat,
   output logic              hit,
   output logic [ADDR_W-1:0] out_addr
);

   logic              tag_eq;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] direct_addr;
   logic [ADDR_W-1:0] page_idx;

   always_comb begin
      tag_eq      = (addr & ~win_emask) == (win_base & ~win_emask);
      offset      = addr & win_emask;
      direct_addr = offset | (win_xlat & ~win_emask);
      page_idx    = offset >> PAGE_BITS;
      hit         = win_en && tag_eq;
      out_addr    = win_sg ? page_idx : direct_addr;
   end

   // R2: a window left disabled never reports a match
   a_r2_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |-> !hit);

endmodule

// File: rtl/dwt_resp_sel.sv
module dwt_resp_sel #(
   parameter int NUM_WIN = 2,
   parameter int ADDR_W  = 32,
   localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   input  logic [NUM_WIN-1:0]              hit_vec,
   input  logic [NUM_WIN-1:0]              sg_vec,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0]  addr_vec,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xlat_vec,
   output logic                            rsp_valid,
   output logic                            rsp_hit,
   output logic [WIN_W-1:0]                rsp_win,
   output logic                            rsp_sg,
   output logic [ADDR_W-1:0]               rsp_addr,
   output logic [ADDR_W-1:0]               rsp_ptbase
);

   logic              nxt_hit;
   logic [WIN_W-1:0]  nxt_win;
   logic              nxt_sg;
   logic [ADDR_W-1:0] nxt_addr;
   logic [ADDR_W-1:0] nxt_ptbase;

   // Walk from the highest index down so the lowest hitting window wins.
   always_comb begin
      nxt_hit    = 1'b0;
      nxt_win    = '0;
      nxt_sg     = 1'b0;
      nxt_addr   = '0;
      nxt_ptbase = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (req_valid && hit_vec[i]) begin
            nxt_hit    = 1'b1;
            nxt_win    = WIN_W'(i);
            nxt_sg     = sg_vec[i];
            nxt_addr   = addr_vec[i];
            nxt_ptbase = sg_vec[i] ? xlat_vec[i] : '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_win    <= '0;
         rsp_sg     <= 1'b0;
         rsp_addr   <= '0;
         rsp_ptbase <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_hit    <= nxt_hit;
         rsp_win    <= nxt_win;
         rsp_sg     <= nxt_sg;
         rsp_addr   <= nxt_addr;
         rsp_ptbase <= nxt_ptbase;
      end
   end

   // R9: one response per request, one edge later
   a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R7: window 0 outranks every other window
   a_r7_low_index_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && hit_vec[0] |=> rsp_hit && rsp_win == '0);
   // R8: a miss leaves every response field at zero
   a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && hit_vec == '0 |=> !rsp_hit && !rsp_sg && rsp_addr == '0
                                     && rsp_ptbase == '0 && rsp_win == '0);

endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate #(
   parameter int NUM_WIN   = 2,
   parameter int ADDR_W    = 32,
   parameter int GRAN_BITS = 20,
   parameter int PAGE_BITS = 13,
   parameter int TB_EN_BIT = 7,
   localparam int BASE_W   = ADDR_W + 2,
   localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WIN_W-1:0]  cfg_win,
   input  logic [2:0]        cfg_sel,
   input  logic [BASE_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WIN_W-1:0]  rsp_win,
   output logic              rsp_sg,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [ADDR_W-1:0] rsp_ptbase,
   output logic              tb_enable,
   output logic              tb_inval
);
   import dwt_pkg::*;

   if (NUM_WIN < 1)                          begin : g_bad_num   $error("NUM_WIN must be at least 1");           end
   if (GRAN_BITS < 1 || GRAN_BITS >= ADDR_W) begin : g_bad_gran  $error("GRAN_BITS must lie inside the address"); end
   if (PAGE_BITS > GRAN_BITS)                begin : g_bad_page  $error("PAGE_BITS may not exceed GRAN_BITS");   end
   if (TB_EN_BIT >= BASE_W)                  begin : g_bad_tben  $error("TB_EN_BIT outside write data");         end

   logic [NUM_WIN-1:0]             win_en, win_sg, hit_vec;
   logic [NUM_WIN-1:0][ADDR_W-1:0] base_vec, emask_vec, xlat_vec, addr_vec;

   logic wr_ctrl, wr_inval;
   assign wr_ctrl  = cfg_we && (cfg_sel == SEL_CTRL);
   assign wr_inval = cfg_we && (cfg_sel == SEL_INVAL);

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      logic sel_me;
      assign sel_me = cfg_we && (cfg_win == WIN_W'(i));

      dwt_win_regs #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) regs_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_base   (sel_me && cfg_sel == SEL_BASE),
         .wr_mask   (sel_me && cfg_sel == SEL_MASK),
         .wr_xlat   (sel_me && cfg_sel == SEL_XLAT),
         .wdata     (cfg_wdata),
         .win_en    (win_en[i]),
         .win_sg    (win_sg[i]),
         .win_base  (base_vec[i]),
         .win_emask (emask_vec[i]),
         .win_xlat  (xlat_vec[i])
      );

      dwt_win_match #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) match_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .addr      (req_addr),
         .win_en    (win_en[i]),
         .win_sg    (win_sg[i]),
         .win_base  (base_vec[i]),
         .win_emask (emask_vec[i]),
         .win_xlat  (xlat_vec[i]),
         .hit       (hit_vec[i]),
         .out_addr  (addr_vec[i])
      );
   end

   dwt_resp_sel #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) sel_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .hit_vec    (hit_vec),
      .sg_vec     (win_sg),
      .addr_vec   (addr_vec),
      .xlat_vec   (xlat_vec),
      .rsp_valid  (rsp_valid),
      .rsp_hit    (rsp_hit),
      .rsp_win    (rsp_win),
      .rsp_sg     (rsp_sg),
      .rsp_addr   (rsp_addr),
      .rsp_ptbase (rsp_ptbase)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tb_enable <= 1'b0;
         tb_inval  <= 1'b0;
      end else begin
         if (wr_ctrl) tb_enable <= cfg_wdata[TB_EN_BIT];
         tb_inval <= wr_inval;
      end
   end

   // R10: the enable flag moves only on a control write
   a_r10_tb_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(tb_enable));
   // R10: the strobe is caused only by an invalidate write one edge earlier
   a_r10_inval_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_inval |=> !tb_inval);
   a_r10_inval_fires: assert property (@(posedge clk) disable iff (!rst_n)
      wr_inval |=> tb_inval);

endmodule

// File: tb/dma_win_xlate_tb_top.sv
`timescale 1ns/1ps
module dma_win_xlate_tb_top;

   localparam int ADDR_W = 32;
   localparam int BASE_W = ADDR_W + 2;
   localparam logic [BASE_W-1:0] EN_DIRECT = 34'h2_0000_0000;
   localparam logic [BASE_W-1:0] EN_SG     = 34'h3_0000_0000;
   localparam logic [BASE_W-1:0] SG_OFF    = 34'h1_0000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [0:0]        cfg_win = '0;
   logic [2:0]        cfg_sel = '0;
   logic [BASE_W-1:0] cfg_wdata = '0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              rsp_valid, rsp_hit, rsp_sg, tb_enable, tb_inval;
   logic [0:0]        rsp_win;
   logic [ADDR_W-1:0] rsp_addr, rsp_ptbase;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   dma_win_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_win(rsp_win), .rsp_sg(rsp_sg), .rsp_addr(rsp_addr),
      .rsp_ptbase(rsp_ptbase), .tb_enable(tb_enable), .tb_inval(tb_inval)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int win, input int sel, input logic [BASE_W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_win = 1'(win); cfg_sel = 3'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Present one lookup; the response is registered at the next edge.
   task automatic look(input logic [ADDR_W-1:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string req, input logic [ADDR_W-1:0] a,
                             input bit hit, input int win, input bit sg,
                             input logic [ADDR_W-1:0] xa, input logic [ADDR_W-1:0] pt);
      look(a);
      check({req, " valid"}, 64'(rsp_valid), 64'd1);
      check({req, " hit"},   64'(rsp_hit),   64'(hit));
      check({req, " win"},   64'(rsp_win),   64'(win));
      check({req, " sg"},    64'(rsp_sg),    64'(sg));
      check({req, " addr"},  64'(rsp_addr),  64'(xa));
      check({req, " ptbase"},64'(rsp_ptbase),64'(pt));
   endtask

   task automatic t_reset;
      check("R1 tb_enable", 64'(tb_enable), 64'd0);
      check("R1 tb_inval",  64'(tb_inval),  64'd0);
      expect_rsp("R1 miss after reset", 32'h4000_1234, 0, 0, 0, 0, 0);
   endtask

   task automatic t_setup;
      wr(0, 0, EN_SG | 34'h0080_0000);
      wr(0, 1, 34'h007F_FFFF);
      wr(0, 2, 34'h0012_0000);
      wr(1, 0, EN_DIRECT | 34'h4000_0000);
      wr(1, 1, 34'h3FFF_FFFF);
      wr(1, 2, 34'h0);
   endtask

   task automatic t_direct;
      expect_rsp("R5 direct low",  32'h4000_1234, 1, 1, 0, 32'h0000_1234, 0);
      expect_rsp("R5 direct top",  32'h7FFF_FFFC, 1, 1, 0, 32'h3FFF_FFFC, 0);
      expect_rsp("R4 above window", 32'h8000_0000, 0, 0, 0, 0, 0);
      expect_rsp("R4 below window", 32'h3FFF_FFFC, 0, 0, 0, 0, 0);
   endtask

   task automatic t_sg;
      expect_rsp("R6 sg mid",   32'h0081_2345, 1, 0, 1, 32'h9,   32'h0012_0000);
      expect_rsp("R6 sg first", 32'h0080_0000, 1, 0, 1, 32'h0,   32'h0012_0000);
      expect_rsp("R6 sg last",  32'h00FF_FFFF, 1, 0, 1, 32'h3FF, 32'h0012_0000);
      expect_rsp("R8 past sg",  32'h0100_0000, 0, 0, 0, 0, 0);
      expect_rsp("R8 before sg",32'h007F_FFFF, 0, 0, 0, 0, 0);
   endtask

   task automatic t_priority;
      wr(1, 0, EN_DIRECT | 34'h0000_0000);
      wr(1, 2, 34'h8000_0000);
      expect_rsp("R7 both hit", 32'h0081_2345, 1, 0, 1, 32'h9, 32'h0012_0000);
      expect_rsp("R7 only w1",  32'h0010_0000, 1, 1, 0, 32'h8010_0000, 0);
      wr(0, 0, SG_OFF | 34'h0080_0000);
      expect_rsp("R2 w0 disabled", 32'h0081_2345, 1, 1, 0, 32'h8081_2345, 0);
   endtask

   task automatic t_gran;
      wr(1, 0, 34'h0);                       // window 1 off
      wr(0, 0, EN_SG | 34'h0080_1234);       // low base bits ignored
      wr(0, 1, 34'h000F_FFFF);               // rounds to a 1 MB window
      expect_rsp("R3 1MB start", 32'h0080_0000, 1, 0, 1, 32'h0,  32'h0012_0000);
      expect_rsp("R3 1MB end",   32'h008F_FFFF, 1, 0, 1, 32'h7F, 32'h0012_0000);
      expect_rsp("R3 1MB past",  32'h0090_0000, 0, 0, 0, 0, 0);
      wr(0, 0, 34'h0080_0000);               // enable bit clear
      expect_rsp("R2 base w/o enable", 32'h0080_0000, 0, 0, 0, 0, 0);
   endtask

   task automatic t_timing;
      look(32'h0);
      @(posedge clk); #1;
      check("R9 idle no valid", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_ctrl;
      wr(0, 3, 34'h80);
      check("R10 tb_enable set", 64'(tb_enable), 64'd1);
      wr(0, 2, 34'h0012_0000);
      check("R10 tb_enable kept", 64'(tb_enable), 64'd1);
      wr(0, 3, 34'h7F);
      check("R10 tb_enable clear", 64'(tb_enable), 64'd0);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = '0;
      @(posedge clk); #1;
      check("R10 inval pulse", 64'(tb_inval), 64'd1);
      cfg_we = 1'b0;
      @(posedge clk); #1;
      check("R10 inval one cycle", 64'(tb_inval), 64'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_setup();
      t_direct();
      t_sg();
      t_priority();
      t_gran();
      t_timing();
      t_ctrl();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule